// File: doc/BRIEF.md
# Small-Page Flash Command Sequencer

This block turns one command request into the latch cycles that a parallel flash device with 512-byte pages expects on its command and address bus. A request carries an 8-bit opcode, an optional column, an optional page address, a 16-bit bus flag and a three-row-cycle flag. The block holds chip enable asserted and drives each cycle as either a command latch (CLE) or an address latch (ALE), with a write-enable pulse placed inside a fixed hold window. For a data-input command, which starts page programming, the block first sends a region pointer command. It picks the first half, the second half or the spare area from the column and rebases the column to that region.

Once the cycles are out, the block decides whether the command needs a ready wait. Some commands finish at once. Others wait the write-to-busy time and then hand the ready wait to an external wait unit through a start/done handshake. When the device has no busy pin, the block waits a fixed chip delay instead. A reset then adds a status command and hands a status poll to the wait unit.

Top module: `sp_flash_cmd_seq`

## Requirements
- R1: Out of reset, chip enable (active low) is high, CLE, ALE and wait_start are low, write enable (active low) is high and busy is low.
- R2: Each latch cycle holds exactly one of CLE or ALE, plus the data byte, for HOLD_CYC clocks. Write enable goes low for HOLD_CYC/2 clocks, starting HOLD_CYC/4 clocks into that window, and the data stays constant while it is low.
- R3: Cycles go out in this order: pointer, opcode, one column byte, page bits 7:0, page bits 15:8, and page bits 23:16 only when row3 is set.
- R4: For opcode 8'h80 a pointer command goes out first. A column of 512 or more sends 8'h50 and reduces the column by 512. A column below 256, or no column at all, sends 8'h00. Any other column sends 8'h01 and reduces the column by 256.
- R5: With wide_bus set, the column is shifted right by one bit before it is sent. This does not happen when the opcode is present and is one of the byte-only opcodes 8'h90, 8'hEC, 8'hEE and 8'hEF.
- R6: The column cycle is left out when col_en is low, the page cycles when page_en is low, and the opcode cycle when cmd_en is low.
- R7: After the last cycle, CLE and ALE drop while chip enable stays low, including after done.
- R8: When cmd_en is low, or the opcode is 8'h10, 8'h60, 8'hD0, 8'h80, 8'h70, 8'h90 or 8'hEF, done follows the cycles and wait_start never pulses.
- R9: Opcode 8'h00 with neither column nor page is sent as a single command cycle and finishes with no wait and no delay.
- R10: With a busy pin (HAS_RB=1), any other command waits TWB_CYC clocks after the strobes drop. It then pulses wait_start with wait_poll low and raises done once wait_done arrives.
- R11: Without a busy pin (HAS_RB=0), any other command except reset waits CHIP_DLY_CYC clocks and raises done, with no wait_start.
- R12: Without a busy pin, reset (8'hFF) waits CHIP_DLY_CYC clocks, sends a status command cycle 8'h70, then pulses wait_start with wait_poll high.
- R13: On a 16-bit bus, the upper data byte is zero during every latch cycle.
- R14: A start while idle raises busy on the next clock. Done pulses for one clock, and busy is low on the clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept the request fields (taken while idle) |
| cmd_en | input | 1 | Opcode present |
| opcode | input | 8 | Command opcode |
| col_en | input | 1 | Column present |
| col | input | COL_W | Column byte offset within page plus spare |
| page_en | input | 1 | Page address present |
| page | input | 24 | Page address |
| wide_bus | input | 1 | Device uses a 16-bit bus |
| row3 | input | 1 | Send a third page address cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| wait_start | output | 1 | One-clock request to the wait unit |
| wait_poll | output | 1 | Wait unit should poll status instead of the busy pin |
| wait_done | input | 1 | Wait unit finished |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Write enable, active low |
| flash_dq | output | DQ_W | Data bus |

## Verification
The bench builds two copies of the block with short timing: HOLD_CYC=4, TWB_CYC=3 and CHIP_DLY_CYC=12. The first copy has a busy pin and a 16-bit bus. It covers the ready-wait handshake, the column shift against byte-only opcodes and the zeroed upper byte. The second copy has no busy pin and an 8-bit bus. It covers the chip-delay path and the reset sequence that appends a status cycle and asks for a status poll. With these short windows, a run can measure the gap between the strobes dropping and wait_start or done exactly, and can try every pointer region and every skip-wait opcode.

// File: rtl/sp_flash_pkg.sv
package sp_flash_pkg;

   localparam logic [7:0] OP_RD_A        = 8'h00;
   localparam logic [7:0] OP_RD_B        = 8'h01;
   localparam logic [7:0] OP_RD_SPARE    = 8'h50;
   localparam logic [7:0] OP_DATA_IN     = 8'h80;
   localparam logic [7:0] OP_PROG        = 8'h10;
   localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
   localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
   localparam logic [7:0] OP_STATUS      = 8'h70;
   localparam logic [7:0] OP_IDENT       = 8'h90;
   localparam logic [7:0] OP_PARAM       = 8'hEC;
   localparam logic [7:0] OP_FEAT_GET    = 8'hEE;
   localparam logic [7:0] OP_FEAT_SET    = 8'hEF;
   localparam logic [7:0] OP_RESET       = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE, ST_LOAD, ST_PTR, ST_CMD, ST_COL, ST_ROW0, ST_ROW1, ST_ROW2,
      ST_TWB, ST_CHIP, ST_STAT, ST_WREQ, ST_WAIT, ST_FIN
   } seq_state_t;

   // opcodes whose address phase is byte-wide even on a 16-bit bus
   function automatic logic byte_only_op(input logic [7:0] op);
      return (op == OP_IDENT) || (op == OP_PARAM) ||
             (op == OP_FEAT_GET) || (op == OP_FEAT_SET);
   endfunction

   // opcodes that end without any ready wait
   function automatic logic skip_wait_op(input logic [7:0] op);
      return (op == OP_PROG) || (op == OP_ERASE_SETUP) || (op == OP_ERASE_GO) ||
             (op == OP_DATA_IN) || (op == OP_STATUS) || (op == OP_IDENT) ||
             (op == OP_FEAT_SET);
   endfunction

   function automatic int step_idx(input seq_state_t s);
      case (s)
         ST_PTR:  return 0;
         ST_CMD:  return 1;
         ST_COL:  return 2;
         ST_ROW0: return 3;
         ST_ROW1: return 4;
         ST_ROW2: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic seq_state_t step_state(input int k);
      case (k)
         0:       return ST_PTR;
         1:       return ST_CMD;
         2:       return ST_COL;
         3:       return ST_ROW0;
         4:       return ST_ROW1;
         default: return ST_ROW2;
      endcase
   endfunction

endpackage

// File: rtl/sp_flash_latch.sv
module sp_flash_latch #(
   parameter int HOLD_CYC = 4,
   parameter int DQ_W     = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            go_cle,
   input  logic [7:0]      go_byte,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic [DQ_W-1:0] dq,
   output logic            done
);
   localparam int CW       = $clog2(HOLD_CYC + 1);
   localparam int WE_FIRST = HOLD_CYC / 4;
   localparam int WE_LAST  = WE_FIRST + HOLD_CYC / 2 - 1;

   logic          active, is_cmd, we_n_q, take;
   logic [CW-1:0] cnt, next_cnt;
   logic          next_active;
   logic [7:0]    byte_q;

   assign done = active && (cnt == CW'(HOLD_CYC - 1));
   assign take = go && (!active || done);

   always_comb begin
      next_active = active;
      next_cnt    = cnt;
      if (take) begin
         next_active = 1'b1;
         next_cnt    = '0;
      end else if (done) begin
         next_active = 1'b0;
         next_cnt    = '0;
      end else if (active) begin
         next_cnt = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         is_cmd <= 1'b0;
         byte_q <= '0;
         we_n_q <= 1'b1;
      end else begin
         active <= next_active;
         cnt    <= next_cnt;
         if (take) begin
            is_cmd <= go_cle;
            byte_q <= go_byte;
         end
         we_n_q <= !(next_active && (next_cnt >= CW'(WE_FIRST)) &&
                     (next_cnt <= CW'(WE_LAST)));
      end
   end

   assign cle  = active && is_cmd;
   assign ale  = active && !is_cmd;
   assign we_n = we_n_q;

   if (DQ_W == 16) begin : g_dq16
      assign dq = {8'h00, byte_q};
   end else begin : g_dq8
      assign dq = byte_q;
   end
endmodule

// File: rtl/sp_flash_delay.sv
module sp_flash_delay #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (go)              cnt <= len;
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/sp_flash_cmd_seq.sv
module sp_flash_cmd_seq
   import sp_flash_pkg::*;
#(
   parameter int PAGE_BYTES   = 512,
   parameter int SPARE_BYTES  = 16,
   parameter int DQ_W         = 16,
   parameter int HOLD_CYC     = 4,
   parameter int TWB_CYC      = 25,
   parameter int CHIP_DLY_CYC = 5000,
   parameter bit HAS_RB       = 1'b1,
   localparam int COL_W       = $clog2(PAGE_BYTES + SPARE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmd_en,
   input  logic [7:0]       opcode,
   input  logic             col_en,
   input  logic [COL_W-1:0] col,
   input  logic             page_en,
   input  logic [23:0]      page,
   input  logic             wide_bus,
   input  logic             row3,
   output logic             busy,
   output logic             done,
   output logic             wait_start,
   output logic             wait_poll,
   input  logic             wait_done,
   output logic             flash_ce_n,
   output logic             flash_cle,
   output logic             flash_ale,
   output logic             flash_we_n,
   output logic [DQ_W-1:0]  flash_dq
);
   localparam int HALF  = PAGE_BYTES / 2;
   localparam int DMAX  = (TWB_CYC > CHIP_DLY_CYC) ? TWB_CYC : CHIP_DLY_CYC;
   localparam int DLY_W = $clog2(DMAX + 1);

   if (DQ_W != 8 && DQ_W != 16) begin : g_bad_dq
      $error("DQ_W must be 8 or 16");
   end
   if (HOLD_CYC < 4) begin : g_bad_hold
      $error("HOLD_CYC must be at least 4");
   end
   if (PAGE_BYTES > 512 || SPARE_BYTES > 256) begin : g_bad_page
      $error("page or spare too large for a one-byte column");
   end
   if (TWB_CYC < 2 || CHIP_DLY_CYC < 2) begin : g_bad_dly
      $error("delays must be at least 2 cycles");
   end

   seq_state_t st, ns;
   logic [7:0]  op_q, ptr_q, colb_q;
   logic [23:0] page_q;
   logic        cmd_en_q, col_en_q, page_en_q, row3_q, ptr_en_q, ce_sel_q;

   // pointer choice and column rebasing from the live request
   logic [COL_W-1:0] col_adj;
   logic [7:0]       ptr_sel;
   always_comb begin
      col_adj = col;
      ptr_sel = OP_RD_A;
      if (cmd_en && opcode == OP_DATA_IN && col_en) begin
         if (col >= COL_W'(PAGE_BYTES)) begin
            ptr_sel = OP_RD_SPARE;
            col_adj = col - COL_W'(PAGE_BYTES);
         end else if (col >= COL_W'(HALF)) begin
            ptr_sel = OP_RD_B;
            col_adj = col - COL_W'(HALF);
         end
      end
      if (wide_bus && !(cmd_en && byte_only_op(opcode)))
         col_adj = col_adj >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= '0; ptr_q <= '0; colb_q <= '0; page_q <= '0;
         cmd_en_q <= 1'b0; col_en_q <= 1'b0; page_en_q <= 1'b0;
         row3_q <= 1'b0; ptr_en_q <= 1'b0; ce_sel_q <= 1'b0;
      end else if (st == ST_IDLE && start) begin
         op_q      <= opcode;
         ptr_q     <= ptr_sel;
         colb_q    <= 8'(col_adj);
         page_q    <= page;
         cmd_en_q  <= cmd_en;
         col_en_q  <= col_en;
         page_en_q <= page_en;
         row3_q    <= row3;
         ptr_en_q  <= cmd_en && (opcode == OP_DATA_IN);
         ce_sel_q  <= 1'b1;
      end
   end

   logic reset_nrb;
   assign reset_nrb = !HAS_RB && cmd_en_q && (op_q == OP_RESET);

   // what follows the last latch cycle
   seq_state_t post_st;
   always_comb begin
      if (!cmd_en_q || skip_wait_op(op_q) ||
          (op_q == OP_RD_A && !col_en_q && !page_en_q)) post_st = ST_FIN;
      else if (HAS_RB)                                  post_st = ST_TWB;
      else                                              post_st = ST_CHIP;
   end

   logic [5:0] step_en;
   assign step_en = {page_en_q && row3_q, page_en_q, page_en_q,
                     col_en_q, cmd_en_q, ptr_en_q};

   seq_state_t step_nxt;
   always_comb begin
      int base;
      base     = (st == ST_LOAD) ? 0 : step_idx(st) + 1;
      step_nxt = post_st;
      for (int k = 5; k >= 0; k--)
         if (step_en[k] && k >= base) step_nxt = step_state(k);
   end

   logic lat_go, lat_cle, lat_done, dly_go, dly_done;
   logic [7:0]       lat_byte;
   logic [DLY_W-1:0] dly_len;

   always_comb begin
      ns = st;
      case (st)
         ST_IDLE: if (start) ns = ST_LOAD;
         ST_LOAD: ns = step_nxt;
         ST_PTR, ST_CMD, ST_COL, ST_ROW0, ST_ROW1, ST_ROW2:
            if (lat_done) ns = step_nxt;
         ST_TWB:  if (dly_done) ns = ST_WREQ;
         ST_CHIP: if (dly_done) ns = reset_nrb ? ST_STAT : ST_FIN;
         ST_STAT: if (lat_done) ns = ST_WREQ;
         ST_WREQ: ns = ST_WAIT;
         ST_WAIT: if (wait_done) ns = ST_FIN;
         default: ns = ST_IDLE;
      endcase
   end

   always_comb begin
      lat_go = 1'b0; lat_cle = 1'b0; lat_byte = '0;
      dly_go = 1'b0; dly_len = '0;
      if (ns != st) begin
         case (ns)
            ST_PTR:  begin lat_go = 1'b1; lat_cle = 1'b1; lat_byte = ptr_q;        end
            ST_CMD:  begin lat_go = 1'b1; lat_cle = 1'b1; lat_byte = op_q;         end
            ST_COL:  begin lat_go = 1'b1;                 lat_byte = colb_q;       end
            ST_ROW0: begin lat_go = 1'b1;                 lat_byte = page_q[7:0];  end
            ST_ROW1: begin lat_go = 1'b1;                 lat_byte = page_q[15:8]; end
            ST_ROW2: begin lat_go = 1'b1;                 lat_byte = page_q[23:16];end
            ST_STAT: begin lat_go = 1'b1; lat_cle = 1'b1; lat_byte = OP_STATUS;    end
            ST_TWB:  begin dly_go = 1'b1; dly_len = DLY_W'(TWB_CYC);              end
            ST_CHIP: begin dly_go = 1'b1; dly_len = DLY_W'(CHIP_DLY_CYC);         end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= ns;
   end

   sp_flash_latch #(.HOLD_CYC(HOLD_CYC), .DQ_W(DQ_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .go(lat_go), .go_cle(lat_cle), .go_byte(lat_byte),
      .cle(flash_cle), .ale(flash_ale), .we_n(flash_we_n), .dq(flash_dq),
      .done(lat_done)
   );

   sp_flash_delay #(.CNT_W(DLY_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .go(dly_go), .len(dly_len), .done(dly_done)
   );

   assign busy       = (st != ST_IDLE);
   assign done       = (st == ST_FIN);
   assign wait_start = (st == ST_WREQ);
   assign wait_poll  = reset_nrb;
   assign flash_ce_n = !ce_sel_q;
endmodule

// File: rtl/sp_flash_cmd_seq_chk.sv
module sp_flash_cmd_seq_chk #(
   parameter int DQ_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            wait_start,
   input logic            flash_ce_n,
   input logic            flash_cle,
   input logic            flash_ale,
   input logic            flash_we_n,
   input logic [DQ_W-1:0] flash_dq
);
   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_cle && flash_ale));

   p_we_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> (flash_cle || flash_ale));

   p_dq_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && !$past(flash_we_n)) |-> $stable(flash_dq));

   p_ce_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flash_ce_n);

   p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wait_start |-> (!flash_cle && !flash_ale));

   p_start_busy_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_done_ends_r14: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind sp_flash_cmd_seq sp_flash_cmd_seq_chk #(.DQ_W(DQ_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .wait_start(wait_start), .flash_ce_n(flash_ce_n), .flash_cle(flash_cle),
   .flash_ale(flash_ale), .flash_we_n(flash_we_n), .flash_dq(flash_dq)
);

// File: tb/sp_flash_cmd_seq_tb.sv
module sp_flash_cmd_seq_tb;
   localparam int HOLD = 4;
   localparam int TWB  = 3;
   localparam int CHIP = 12;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, start = 1'b0, cmd_en = 1'b0, col_en = 1'b0, page_en = 1'b0;
   logic wide_bus = 1'b0, row3 = 1'b0, wait_done = 1'b0, sel = 1'b0;
   logic [7:0]  opcode = '0;
   logic [9:0]  col = '0;
   logic [23:0] page = '0;

   logic a_busy, a_done, a_ws, a_poll, a_ce_n, a_cle, a_ale, a_we_n;
   logic b_busy, b_done, b_ws, b_poll, b_ce_n, b_cle, b_ale, b_we_n;
   logic [15:0] a_dq;
   logic [7:0]  b_dq;

   sp_flash_cmd_seq #(.DQ_W(16), .HOLD_CYC(HOLD), .TWB_CYC(TWB),
                      .CHIP_DLY_CYC(CHIP), .HAS_RB(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start && !sel), .cmd_en(cmd_en),
      .opcode(opcode), .col_en(col_en), .col(col), .page_en(page_en),
      .page(page), .wide_bus(wide_bus), .row3(row3), .busy(a_busy),
      .done(a_done), .wait_start(a_ws), .wait_poll(a_poll),
      .wait_done(wait_done), .flash_ce_n(a_ce_n), .flash_cle(a_cle),
      .flash_ale(a_ale), .flash_we_n(a_we_n), .flash_dq(a_dq));

   sp_flash_cmd_seq #(.DQ_W(8), .HOLD_CYC(HOLD), .TWB_CYC(TWB),
                      .CHIP_DLY_CYC(CHIP), .HAS_RB(1'b0)) u_nrb (
      .clk(clk), .rst_n(rst_n), .start(start && sel), .cmd_en(cmd_en),
      .opcode(opcode), .col_en(col_en), .col(col), .page_en(page_en),
      .page(page), .wide_bus(wide_bus), .row3(row3), .busy(b_busy),
      .done(b_done), .wait_start(b_ws), .wait_poll(b_poll),
      .wait_done(wait_done), .flash_ce_n(b_ce_n), .flash_cle(b_cle),
      .flash_ale(b_ale), .flash_we_n(b_we_n), .flash_dq(b_dq));

   wire        m_busy = sel ? b_busy : a_busy;
   wire        m_done = sel ? b_done : a_done;
   wire        m_ws   = sel ? b_ws   : a_ws;
   wire        m_poll = sel ? b_poll : a_poll;
   wire        m_ce_n = sel ? b_ce_n : a_ce_n;
   wire        m_cle  = sel ? b_cle  : a_cle;
   wire        m_ale  = sel ? b_ale  : a_ale;
   wire        m_we_n = sel ? b_we_n : a_we_n;
   wire [15:0] m_dq   = sel ? {8'h00, b_dq} : a_dq;

   int checks = 0, failures = 0;
   logic finished = 1'b0;

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // bus monitor, sampled on the falling edge
   logic [8:0] lat_log [0:15];
   int   n_lat, low_cnt, strobe_cnt, ws_cnt, ws_gap, done_gap, idle;
   logic prev_we, ws_poll, bad_pulse, bad_dq, bad_upper, bad_strobe;
   logic [15:0] dq_first;

   task automatic clear_mon();
      n_lat = 0; strobe_cnt = 0; ws_cnt = 0; ws_gap = -1; done_gap = -1;
      bad_pulse = 0; bad_dq = 0; bad_upper = 0; bad_strobe = 0; ws_poll = 0;
   endtask

   initial begin
      clear_mon();
      prev_we = 1'b1; idle = 0; low_cnt = 0; dq_first = '0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!m_we_n) begin
            if (prev_we) begin low_cnt = 1; dq_first = m_dq; end
            else begin low_cnt++; if (m_dq != dq_first) bad_dq = 1; end
         end else if (!prev_we) begin
            if (n_lat < 16) lat_log[n_lat] = {m_cle, m_dq[7:0]};
            n_lat++;
            if (low_cnt != HOLD / 2) bad_pulse = 1;
            if (m_dq[15:8] != 8'h00) bad_upper = 1;
            if (m_cle == m_ale) bad_strobe = 1;
         end
         prev_we = m_we_n;
         if (m_ws) begin ws_cnt++; ws_gap = idle; ws_poll = m_poll; end
         if (m_done) done_gap = idle;
         if (m_cle || m_ale) begin idle = 0; strobe_cnt++; end
         else idle++;
      end
   end

   // expected cycle list, built from the requirements
   logic [8:0] exp_log [0:15];
   int exp_n;
   task automatic push(input logic is_cmd, input logic [7:0] b);
      exp_log[exp_n] = {is_cmd, b};
      exp_n++;
   endtask

   task automatic build_exp(input logic ce, input logic [7:0] op, input logic cen,
                            input int c, input logic pen, input logic [23:0] p,
                            input logic w, input logic r3);
      int cc = c;
      exp_n = 0;
      if (ce && op == 8'h80) begin                     // R4
         if (!cen || cc < 256) push(1, 8'h00);
         else if (cc >= 512) begin push(1, 8'h50); cc -= 512; end
         else begin push(1, 8'h01); cc -= 256; end
      end
      if (ce) push(1, op);
      if (cen) begin                                   // R5
         if (w && !(ce && (op == 8'h90 || op == 8'hEC || op == 8'hEE || op == 8'hEF)))
            cc = cc / 2;
         push(0, 8'(cc));
      end
      if (pen) begin
         push(0, p[7:0]); push(0, p[15:8]);
         if (r3) push(0, p[23:16]);
      end
   endtask

   logic saw_busy;
   task automatic issue(input logic s, input logic ce, input logic [7:0] op,
                        input logic cen, input int c, input logic pen,
                        input logic [23:0] p, input logic w, input logic r3);
      int cd = 0, tmo = 0;
      logic got = 0;
      @(posedge clk); #1;
      clear_mon();
      sel = s; cmd_en = ce; opcode = op; col_en = cen; col = 10'(c);
      page_en = pen; page = p; wide_bus = w; row3 = r3; start = 1'b1;
      build_exp(ce, op, cen, c, pen, p, w, r3);
      @(posedge clk); #1;
      start = 1'b0;
      saw_busy = m_busy;
      while (!got && tmo < 2000) begin
         if (m_done) got = 1;
         @(posedge clk); #1;
         wait_done = 1'b0;
         if (cd > 0) begin cd--; if (cd == 0) wait_done = 1'b1; end
         if (m_ws) cd = 3;
         tmo++;
      end
      wait_done = 1'b0;
      check(got, "R14 done seen", int'(got), 1);
      check(!m_busy, "R14 busy low after done", int'(m_busy), 0);
      check(saw_busy, "R14 busy after start", int'(saw_busy), 1);
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic check_seq(input string tag);
      check(n_lat == exp_n, {tag, " cycle count"}, n_lat, exp_n);
      for (int i = 0; i < exp_n && i < n_lat && i < 16; i++)
         check(lat_log[i] == exp_log[i], {tag, " cycle value"}, int'(lat_log[i]), int'(exp_log[i]));
      check(!bad_pulse && !bad_dq && !bad_strobe, "R2 pulse/data/strobe shape",
            int'({bad_pulse, bad_dq, bad_strobe}), 0);
      check(strobe_cnt == n_lat * HOLD, "R2 strobe hold length", strobe_cnt, n_lat * HOLD);
      check(!m_ce_n && !m_cle && !m_ale, "R7 ce held, strobes low",
            int'({m_ce_n, m_cle, m_ale}), 0);
   endtask

   task automatic t_reset();
      check(a_ce_n && !a_cle && !a_ale && a_we_n && !a_busy && !a_ws,
            "R1 reset outputs", int'({a_ce_n, a_cle, a_ale, a_we_n, a_busy, a_ws}), 6'b100100);
   endtask

   task automatic t_read_full();
      issue(0, 1, 8'h00, 1, 'h23, 1, 24'h012345, 0, 1);
      check_seq("R3 read three rows");
      check(ws_cnt == 1 && !ws_poll, "R10 wait requested by pin", ws_cnt, 1);
      check(ws_gap >= TWB && ws_gap <= TWB + 2, "R10 write-to-busy gap", ws_gap, TWB);
      check(!bad_upper, "R13 upper byte zero", int'(bad_upper), 0);
   endtask

   task automatic t_read_two_rows();
      issue(0, 1, 8'h50, 1, 'h05, 1, 24'hABCDEF, 0, 0);
      check_seq("R3 two row cycles");
      check(ws_cnt == 1, "R10 spare read waits", ws_cnt, 1);
   endtask

   task automatic t_data_in();
      int cols[3] = '{'h10, 300, 515};
      foreach (cols[i]) begin
         issue(0, 1, 8'h80, 1, cols[i], 1, 24'h000102, 0, 0);
         check_seq("R4 pointer and rebase");
         check(ws_cnt == 0, "R8 data input no wait", ws_cnt, 0);
      end
      issue(0, 1, 8'h80, 1, 300, 1, 24'h000102, 1, 0);
      check_seq("R5 rebase then shift");
   endtask

   task automatic t_wide();
      issue(0, 1, 8'h00, 1, 'h1FE, 1, 24'h000077, 1, 0);
      check_seq("R5 wide column shifted");
      issue(0, 1, 8'h90, 1, 'h20, 0, 24'h0, 1, 0);
      check_seq("R5 byte-only opcode unshifted");
      check(ws_cnt == 0, "R8 read id no wait", ws_cnt, 0);
      check(!bad_upper, "R13 upper byte zero", int'(bad_upper), 0);
   endtask

   task automatic t_absent();
      issue(0, 1, 8'h60, 0, 0, 1, 24'h00A1B2, 0, 1);
      check_seq("R6 column omitted");
      check(ws_cnt == 0, "R8 erase setup no wait", ws_cnt, 0);
      issue(0, 0, 8'h00, 1, 'h44, 0, 24'h0, 0, 0);
      check_seq("R6 opcode omitted");
      check(ws_cnt == 0, "R8 null opcode no wait", ws_cnt, 0);
      issue(0, 0, 8'h00, 0, 0, 0, 24'h0, 0, 0);
      check(n_lat == 0 && ws_cnt == 0, "R6 empty request", n_lat, 0);
   endtask

   task automatic t_no_wait_list();
      logic [7:0] ops[4] = '{8'h10, 8'hD0, 8'h70, 8'hEF};
      foreach (ops[i]) begin
         issue(0, 1, ops[i], 0, 0, 0, 24'h0, 0, 0);
         check_seq("R8 skip-wait opcode");
         check(ws_cnt == 0, "R8 skip-wait opcode no wait", ws_cnt, 0);
      end
   endtask

   task automatic t_status_exit();
      issue(0, 1, 8'h00, 0, 0, 0, 24'h0, 0, 0);
      check_seq("R9 bare read");
      check(ws_cnt == 0, "R9 bare read no wait", ws_cnt, 0);
      check(done_gap >= 0 && done_gap <= 2, "R9 bare read no delay", done_gap, 0);
   endtask

   task automatic t_rb_reset();
      issue(0, 1, 8'hFF, 0, 0, 0, 24'h0, 0, 0);
      check_seq("R10 reset with pin");
      check(ws_cnt == 1 && !ws_poll, "R10 reset waits on pin", ws_cnt, 1);
   endtask

   task automatic t_nrb_read();
      issue(1, 1, 8'h00, 1, 'h3C, 1, 24'h112233, 0, 0);
      check_seq("R11 read without pin");
      check(ws_cnt == 0, "R11 no wait request", ws_cnt, 0);
      check(done_gap >= CHIP, "R11 chip delay applied", done_gap, CHIP);
   endtask

   task automatic t_nrb_reset();
      issue(1, 1, 8'hFF, 0, 0, 0, 24'h0, 0, 0);
      check(n_lat == 2, "R12 reset plus status cycles", n_lat, 2);
      check(lat_log[0] == {1'b1, 8'hFF}, "R12 reset cycle", int'(lat_log[0]), 'h1FF);
      check(lat_log[1] == {1'b1, 8'h70}, "R12 status cycle", int'(lat_log[1]), 'h170);
      check(ws_cnt == 1 && ws_poll, "R12 status poll requested", int'({ws_cnt[0], ws_poll}), 3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      t_read_full();
      t_read_two_rows();
      t_data_in();
      t_wide();
      t_absent();
      t_no_wait_list();
      t_status_exit();
      t_rb_reset();
      t_nrb_read();
      t_nrb_reset();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule